// File: doc/BRIEF.md
# Twelve-Cell Arithmetic Cluster with Shared Carry Logic

This block groups twelve configurable arithmetic cells around one central carry unit. Each cell holds a 20-bit configuration word. From that word and its four data inputs it produces a lookup result `y`. It also exports two terms to the carry unit: a propagate flag and an inverted generate flag.

The carry unit never ripples carries from cell to cell inside the cells. It evaluates one recurrence over all twelve cells, starting from the cluster carry-in. It hands back every intermediate carry and the final carry-out. Each cell then forms its sum bit from its lookup result and the carry of the cell below it.

With a suitable configuration word, the cluster acts as a 12-bit adder, a comparator or any other bit-sliced function that needs a carry chain. The whole block is combinational and holds no state.

Top module: `cluster_carry_unit`

## Requirements
- R1: Each cell's `y` equals bit `k` of its configuration word, where the 4-bit index `k` is formed with `a` as bit 3, `d` as bit 2, `c` as bit 1 and `b` as bit 0.
- R2: Configuration bits 19:18 choose the cell's propagate flag: 00 gives 0, 01 gives `y`, and 10 or 11 gives 1.
- R3: Configuration bits 17:16 choose the inverted generate flag. 00 gives 1 and 10 gives 0. 01 gives the inverse of the LUT entry at index `{0,d,c,b}`, and 11 gives the inverse of the entry at `{1,d,c,b}`.
- R4: Each cell's sum bit is `y` XOR that cell's carry input. Cell 0 takes the cluster carry-in. Cell n (n>0) takes carry tap n-1.
- R5: Carry tap n equals the carry below it (tap n-1, or the cluster carry-in for n=0) when the propagate flag is 1. Otherwise it equals the inverse of the inverted generate flag.
- R6: The cluster carry-out equals carry tap 11.
- R7: Every output follows its inputs without any clock edge; the block holds no state.
- R8: Give every cell configuration word 0x555AA, drive operand bits on `a` and `b`, and hold `c` and `d` at 0. The sum bits and the carry-out then equal the 13-bit result of a + b + carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 12 | Per-cell input `a` (LUT index bit 3) |
| op_b | input | 12 | Per-cell input `b` (LUT index bit 0) |
| op_c | input | 12 | Per-cell input `c` (LUT index bit 1) |
| op_d | input | 12 | Per-cell input `d` (LUT index bit 2) |
| cfg_flat | input | 240 | Configuration words, cell n in bits 20n+19 : 20n |
| carry_in | input | 1 | Cluster carry-in |
| y_out | output | 12 | Per-cell lookup result |
| sum_out | output | 12 | Per-cell sum bit |
| prop_out | output | 12 | Per-cell propagate flag |
| ubar_out | output | 12 | Per-cell inverted generate flag |
| carry_tap | output | 12 | Intermediate carries, bit n from cell n |
| carry_out | output | 1 | Cluster carry-out |

## Verification
The bound checker evaluates local relations whenever the inputs settle, for every cell:
- the sum bit against the lookup result and the carry from below;
- each carry tap against the propagate and inverted generate flags and the carry beneath it;
- the fixed propagate and inverted-generate modes of the configuration word;
- the carry-out against the top tap.

Some behaviour needs the bench's own scenarios instead. The full mapping from the configuration word through the LUT index to `y` is one example. Long propagate runs that carry the carry-in through all twelve cells are another. So is the claim that an adder configuration gives arithmetically correct results. The last is shown by comparing against a + b + carry-in over random and extreme operands.

// File: rtl/cluster_pkg.sv
`timescale 1ns/1ps
package cluster_pkg;
    localparam int CFG_W   = 20;
    localparam int LUT_W   = 16;
    localparam int IDX_W   = 4;

    typedef enum logic [1:0] {
        PSEL_ZERO = 2'b00,
        PSEL_Y    = 2'b01,
        PSEL_ONE  = 2'b10,
        PSEL_ONE2 = 2'b11
    } psel_t;

    typedef enum logic [1:0] {
        GSEL_ONE   = 2'b00,
        GSEL_NF0   = 2'b01,
        GSEL_ZERO  = 2'b10,
        GSEL_NF1   = 2'b11
    } gsel_t;

    typedef struct packed {
        psel_t             psel;
        gsel_t             gsel;
        logic [LUT_W-1:0]  lut;
    } cell_cfg_t;
endpackage

// File: rtl/cluster_cell.sv
`timescale 1ns/1ps
module cluster_cell
    import cluster_pkg::*;
(
    input  logic      a,
    input  logic      b,
    input  logic      c,
    input  logic      d,
    input  cell_cfg_t cfg,
    input  logic      cin,
    output logic      y,
    output logic      s,
    output logic      p,
    output logic      ub
);
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_f0;
    logic [IDX_W-1:0] idx_f1;
    logic             f0;
    logic             f1;

    always_comb begin
        idx    = {a, d, c, b};
        idx_f0 = {1'b0, d, c, b};
        idx_f1 = {1'b1, d, c, b};
        y      = cfg.lut[idx];
        f0     = cfg.lut[idx_f0];
        f1     = cfg.lut[idx_f1];
    end

    always_comb begin
        unique case (cfg.psel)
            PSEL_ZERO: p = 1'b0;
            PSEL_Y:    p = y;
            PSEL_ONE,
            PSEL_ONE2: p = 1'b1;
            default:   p = 1'b0;
        endcase
    end

    always_comb begin
        unique case (cfg.gsel)
            GSEL_ONE:  ub = 1'b1;
            GSEL_NF0:  ub = ~f0;
            GSEL_ZERO: ub = 1'b0;
            GSEL_NF1:  ub = ~f1;
            default:   ub = 1'b1;
        endcase
    end

    assign s = y ^ cin;
endmodule

// File: rtl/carry_chain.sv
`timescale 1ns/1ps
module carry_chain #(
    parameter int NCELL = 12
) (
    input  logic             ci,
    input  logic [NCELL-1:0] prop,
    input  logic [NCELL-1:0] ubar,
    output logic [NCELL-1:0] cc,
    output logic             co
);
    genvar n;
    generate
        for (n = 0; n < NCELL; n++) begin : g_stage
            logic below;
            if (n == 0) begin : g_first
                assign below = ci;
            end else begin : g_rest
                assign below = cc[n-1];
            end
            assign cc[n] = (~prop[n] & ~ubar[n]) | (prop[n] & below);
        end
    endgenerate

    assign co = cc[NCELL-1];
endmodule

// File: rtl/cluster_carry_unit.sv
`timescale 1ns/1ps
module cluster_carry_unit
    import cluster_pkg::*;
#(
    parameter int NCELL = 12
) (
    input  logic [NCELL-1:0]       op_a,
    input  logic [NCELL-1:0]       op_b,
    input  logic [NCELL-1:0]       op_c,
    input  logic [NCELL-1:0]       op_d,
    input  logic [NCELL*CFG_W-1:0] cfg_flat,
    input  logic                   carry_in,
    output logic [NCELL-1:0]       y_out,
    output logic [NCELL-1:0]       sum_out,
    output logic [NCELL-1:0]       prop_out,
    output logic [NCELL-1:0]       ubar_out,
    output logic [NCELL-1:0]       carry_tap,
    output logic                   carry_out
);
    logic [NCELL-1:0] cell_cin;

    genvar n;
    generate
        for (n = 0; n < NCELL; n++) begin : g_cell
            if (n == 0) begin : g_c0
                assign cell_cin[n] = carry_in;
            end else begin : g_cn
                assign cell_cin[n] = carry_tap[n-1];
            end
            cluster_cell u_cell (
                .a   (op_a[n]),
                .b   (op_b[n]),
                .c   (op_c[n]),
                .d   (op_d[n]),
                .cfg (cell_cfg_t'(cfg_flat[n*CFG_W +: CFG_W])),
                .cin (cell_cin[n]),
                .y   (y_out[n]),
                .s   (sum_out[n]),
                .p   (prop_out[n]),
                .ub  (ubar_out[n])
            );
        end
    endgenerate

    carry_chain #(.NCELL(NCELL)) u_chain (
        .ci   (carry_in),
        .prop (prop_out),
        .ubar (ubar_out),
        .cc   (carry_tap),
        .co   (carry_out)
    );
endmodule

// File: rtl/cluster_carry_checker.sv
`timescale 1ns/1ps
module cluster_carry_checker
    import cluster_pkg::*;
#(
    parameter int NCELL = 12
) (
    input logic [NCELL*CFG_W-1:0] cfg_flat,
    input logic                   carry_in,
    input logic [NCELL-1:0]       y_out,
    input logic [NCELL-1:0]       sum_out,
    input logic [NCELL-1:0]       prop_out,
    input logic [NCELL-1:0]       ubar_out,
    input logic [NCELL-1:0]       carry_tap,
    input logic                   carry_out
);
    logic settled;

    always_comb begin
        settled = !$isunknown({cfg_flat, carry_in, y_out, sum_out,
                               prop_out, ubar_out, carry_tap, carry_out});
        if (settled) begin
            assert_cout_R6: assert (carry_out == carry_tap[NCELL-1])
                else $error("carry_out differs from top tap");
            for (int n = 0; n < NCELL; n++) begin
                assert_sum_R4: assert ((sum_out[n] ^ y_out[n]) ==
                                       ((n == 0) ? carry_in : carry_tap[(n == 0) ? 0 : n-1]))
                    else $error("sum bit %0d inconsistent", n);
                if (prop_out[n]) begin
                    assert_pass_R5: assert (carry_tap[n] ==
                                            ((n == 0) ? carry_in : carry_tap[(n == 0) ? 0 : n-1]))
                        else $error("tap %0d did not pass carry", n);
                end else begin
                    assert_gen_R5: assert (carry_tap[n] != ubar_out[n])
                        else $error("tap %0d not from generate", n);
                end
                if (cfg_flat[n*CFG_W+19 -: 2] == 2'b00) begin
                    assert_pzero_R2: assert (!prop_out[n])
                        else $error("propagate %0d should be 0", n);
                end
                if (cfg_flat[n*CFG_W+19]) begin
                    assert_pone_R2: assert (prop_out[n])
                        else $error("propagate %0d should be 1", n);
                end
                if (cfg_flat[n*CFG_W+17 -: 2] == 2'b00) begin
                    assert_gone_R3: assert (ubar_out[n])
                        else $error("ubar %0d should be 1", n);
                end
                if (cfg_flat[n*CFG_W+17 -: 2] == 2'b10) begin
                    assert_gzero_R3: assert (!ubar_out[n])
                        else $error("ubar %0d should be 0", n);
                end
            end
        end
    end
endmodule

bind cluster_carry_unit cluster_carry_checker #(.NCELL(NCELL)) u_checker (
    .cfg_flat  (cfg_flat),
    .carry_in  (carry_in),
    .y_out     (y_out),
    .sum_out   (sum_out),
    .prop_out  (prop_out),
    .ubar_out  (ubar_out),
    .carry_tap (carry_tap),
    .carry_out (carry_out)
);

// File: tb/cluster_carry_unit_test.sv
`timescale 1ns/1ps
module cluster_carry_unit_test;
    localparam int N  = 12;
    localparam int CW = 20;
    localparam logic [CW-1:0] ADD_CFG = 20'h555AA;

    typedef struct {
        bit          is_add;
        logic [N-1:0] y, s, p, ub, cc;
        logic        co;
        logic [N:0]  total;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [N-1:0]    op_a = '0, op_b = '0, op_c = '0, op_d = '0;
    logic [N*CW-1:0] cfg_flat = '0;
    logic            carry_in = 1'b0;
    logic [N-1:0]    y_out, sum_out, prop_out, ubar_out, carry_tap;
    logic            carry_out;

    int total = 0;
    int bad   = 0;
    exp_t expq[$];

    cluster_carry_unit #(.NCELL(N)) uut (
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .cfg_flat(cfg_flat), .carry_in(carry_in),
        .y_out(y_out), .sum_out(sum_out), .prop_out(prop_out),
        .ubar_out(ubar_out), .carry_tap(carry_tap), .carry_out(carry_out)
    );

    task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [N*CW-1:0] cfg, input logic [N-1:0] a, b, c, d,
                                   input logic ci);
        exp_t e;
        logic below;
        e.is_add = 1'b0;
        e.total  = '0;
        below = ci;
        for (int n = 0; n < N; n++) begin
            logic [CW-1:0] w;
            logic yn, f0, f1;
            w  = cfg[n*CW +: CW];
            yn = w[{a[n], d[n], c[n], b[n]}];
            f0 = w[{1'b0, d[n], c[n], b[n]}];
            f1 = w[{1'b1, d[n], c[n], b[n]}];
            e.y[n] = yn;
            case (w[19:18])
                2'b00:   e.p[n] = 1'b0;
                2'b01:   e.p[n] = yn;
                default: e.p[n] = 1'b1;
            endcase
            case (w[17:16])
                2'b00:   e.ub[n] = 1'b1;
                2'b01:   e.ub[n] = ~f0;
                2'b10:   e.ub[n] = 1'b0;
                default: e.ub[n] = ~f1;
            endcase
            e.s[n]  = yn ^ below;
            e.cc[n] = e.p[n] ? below : ~e.ub[n];
            below   = e.cc[n];
        end
        e.co = below;
        return e;
    endfunction

    task automatic drive_raw(input logic [N*CW-1:0] cfg, input logic [N-1:0] a, b, c, d,
                             input logic ci);
        @(posedge clk);
        #1;
        cfg_flat = cfg; op_a = a; op_b = b; op_c = c; op_d = d; carry_in = ci;
        expq.push_back(model(cfg, a, b, c, d, ci));
    endtask

    task automatic drive_add(input logic [N-1:0] a, b, input logic ci);
        exp_t e;
        @(posedge clk);
        #1;
        cfg_flat = {N{ADD_CFG}}; op_a = a; op_b = b; op_c = '0; op_d = '0; carry_in = ci;
        e = '{default: '0};
        e.is_add = 1'b1;
        e.total  = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci};
        expq.push_back(e);
    endtask

    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            if (e.is_add) begin
                check("R8 sum",       {1'b0, sum_out}, {1'b0, e.total[N-1:0]});
                check("R8 carry_out", {{N{1'b0}}, carry_out}, {{N{1'b0}}, e.total[N]});
            end else begin
                check("R1 y",       {1'b0, y_out},    {1'b0, e.y});
                check("R2 prop",    {1'b0, prop_out}, {1'b0, e.p});
                check("R3 ubar",    {1'b0, ubar_out}, {1'b0, e.ub});
                check("R4 sum",     {1'b0, sum_out},  {1'b0, e.s});
                check("R5 taps",    {1'b0, carry_tap}, {1'b0, e.cc});
                check("R6 cout",    {{N{1'b0}}, carry_out}, {{N{1'b0}}, e.co});
            end
        end
    end

    initial begin
        #(4 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N*CW-1:0] rcfg;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: zero config gives y=0, p=0, ubar=1, no carries
        drive_raw('0, '0, '0, '0, '0, 1'b0);
        // R2 and R5: all cells forced to propagate carry a carry-in to the top
        drive_raw({N{20'h80000}}, '0, '0, '0, '0, 1'b1);
        drive_raw({N{20'hC0000}}, '0, '0, '0, '0, 1'b0);
        // R3: forced generate (ubar=0) with no propagate
        drive_raw({N{20'h20000}}, '1, '0, '0, '0, 1'b0);
        // R1: single-entry LUTs across every index
        for (int k = 0; k < 16; k++) begin
            drive_raw({N{20'h00001 << k}}, {N{k[3]}}, {N{k[0]}}, {N{k[1]}}, {N{k[2]}}, 1'b0);
        end
        // random configuration and inputs
        for (int t = 0; t < 300; t++) begin
            for (int n = 0; n < N; n++) rcfg[n*CW +: CW] = CW'($urandom);
            drive_raw(rcfg, N'($urandom), N'($urandom), N'($urandom), N'($urandom), 1'($urandom));
        end
        // R8: adder corners
        drive_add(12'hFFF, 12'h000, 1'b1);
        drive_add(12'hFFF, 12'hFFF, 1'b1);
        drive_add(12'h000, 12'h000, 1'b0);
        drive_add(12'h800, 12'h800, 1'b0);
        for (int t = 0; t < 300; t++) begin
            drive_add(N'($urandom), N'($urandom), 1'($urandom));
        end
        repeat (3) @(posedge clk);
        // R7: carry-out reacts to carry_in between clock edges
        @(posedge clk);
        #1;
        cfg_flat = {N{ADD_CFG}}; op_a = 12'hFFF; op_b = '0; op_c = '0; op_d = '0; carry_in = 1'b0;
        #0.5;
        check("R7 cout low",  {{N{1'b0}}, carry_out}, '0);
        carry_in = 1'b1;
        #0.5;
        check("R7 cout high", {{N{1'b0}}, carry_out}, {{N{1'b0}}, 1'b1});
        check("R7 sum",       {1'b0, sum_out}, '0);
        repeat (2) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule